// File: doc/BRIEF.md
# Selectable IR Carrier Generator

This block drives the output transistor of an infrared remote-control pin. It runs straight from the oscillator clock and makes a carrier square wave whose period and active time are picked by a 3-bit pulse-mode register. The program loads that register through a strobe. It switches the carrier on and off through set and clear strobes aimed at the pin. One mode turns off the carrier, and the pin then works as a plain static open-drain output.

The pin has two outputs. `out_en` says that the pin's output latch is enabled and that the chip is not stopped. `drv_on` says that the open-drain transistor is conducting in the current cycle, which pulls the pin low. When `drv_on` is 0, the pin is released to high impedance. Stop mode releases the pin but keeps the latch and the mode. When stop ends, the pin goes back to the state it had before.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, `out_en` and `drv_on` are 0 and the mode is 0. A set command with no mode load yields the mode-0 waveform.
- R2: While running, modes 0, 1 and 6 have a 96-clock period with 48, 32 and 24 active clocks. Every period starts with its active clocks (`drv_on`=1), and the rest of the period follows with `drv_on`=0.
- R3: Modes 2 and 3 have a 64-clock period with 32 and 16 active clocks, in the same active-first order.
- R4: Mode 4 has an 88-clock period with 32 active clocks. Mode 7 has a 92-clock period with 46 active clocks.
- R5: In mode 5 there is no carrier. While the latch is enabled, `drv_on` stays 1 in every cycle. After a clear it stays 0.
- R6: A set strobe enables the latch from the next clock. A clear strobe disables it from the next clock. Clear wins when both come in the same cycle. While the latch is disabled, `out_en` and `drv_on` stay 0. A carrier started by a set begins with a full active phase.
- R7: While `stop` is 1, `out_en` and `drv_on` are 0 in that same cycle. When `stop` falls, the latch state and mode come back, and a carrier restarts at the first clock of its active phase.
- R8: A mode load takes effect at the next clock. It restarts the period so that the new waveform begins with its full active phase.
- R9: Only bits [2:0] of the loaded value select the mode, and bit 3 is ignored. For example, 8 selects mode 0 and 13 selects mode 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_load | input | 1 | Loads the pulse-mode register from `mode_val` |
| mode_val | input | 4 | Value to load; bits [2:0] used |
| pin_set | input | 1 | Enables the pin's output latch |
| pin_clr | input | 1 | Disables the pin's output latch |
| stop | input | 1 | Stop mode; releases the pin while high |
| out_en | output | 1 | Latch enabled and not stopped |
| drv_on | output | 1 | Open-drain transistor conducting (pin low) |

## Verification
The bench records every mode's waveform over more than two periods, clock by clock. An off-by-one period count or a swapped phase order would therefore show up as a mismatch at the wrap point.

Mode loads are made in the middle of a running carrier. A design that kept counting from the old position would emit a truncated first pulse.

Stop is entered partway through a period and then left. A design that did not release the pin immediately, or that resumed mid-period, would be caught.

Values with bit 3 set check that the mode decode is masked. A simultaneous set and clear checks the priority between the two strobes.

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_load,
  input  logic [3:0] mode_val,
  input  logic       pin_set,
  input  logic       pin_clr,
  input  logic       stop,
  output logic       out_en,
  output logic       drv_on
);

  localparam logic [2:0] STATIC_MODE = 3'd5;

  function automatic logic [CNT_W-1:0] period_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd1, 3'd6: period_of = CNT_W'(96);
      3'd2, 3'd3:       period_of = CNT_W'(64);
      3'd4:             period_of = CNT_W'(88);
      3'd7:             period_of = CNT_W'(92);
      default:          period_of = CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] active_of(input logic [2:0] m);
    case (m)
      3'd0:       active_of = CNT_W'(48);
      3'd1, 3'd2: active_of = CNT_W'(32);
      3'd3:       active_of = CNT_W'(16);
      3'd4:       active_of = CNT_W'(32);
      3'd6:       active_of = CNT_W'(24);
      3'd7:       active_of = CNT_W'(46);
      default:    active_of = CNT_W'(1);
    endcase
  endfunction

  logic [2:0]       mode_q;
  logic             latch_q;
  logic [CNT_W-1:0] cnt_q;

  wire running  = latch_q & ~stop & (mode_q != STATIC_MODE);
  wire cnt_wrap = (cnt_q == period_of(mode_q) - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      latch_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (mode_load) mode_q <= mode_val[2:0];
      if (pin_clr)      latch_q <= 1'b0;
      else if (pin_set) latch_q <= 1'b1;
      if (mode_load || !running || cnt_wrap) cnt_q <= '0;
      else                                   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign out_en = latch_q & ~stop;
  assign drv_on = out_en & ((mode_q == STATIC_MODE) | (cnt_q < active_of(mode_q)));

endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic             pin_set,
  input logic             pin_clr,
  input logic             stop,
  input logic             out_en,
  input logic             drv_on,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q
);

  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (!out_en && !drv_on));

  a_r6_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !drv_on);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pin_clr |=> !out_en);

  a_r6_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_set && !pin_clr) |=> (stop || out_en));

  a_r8_load_starts_active: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (!out_en || drv_on));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 || mode_q == 3'd3) |-> (cnt_q < CNT_W'(64)));

endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .pin_set(pin_set),
  .pin_clr(pin_clr), .stop(stop), .out_en(out_en), .drv_on(drv_on),
  .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/ir_carrier_gen_bench.sv
`timescale 1ns/1ps
module ir_carrier_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [3:0] mode_val = 4'd0;
  logic       pin_set = 1'b0;
  logic       pin_clr = 1'b0;
  logic       stop = 1'b0;
  logic       out_en;
  logic       drv_on;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ir_carrier_gen u_ir_carrier_gen (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_val(mode_val),
    .pin_set(pin_set), .pin_clr(pin_clr), .stop(stop),
    .out_en(out_en), .drv_on(drv_on)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe kinds: 0 set, 1 clear, 2 load, 3 set+clear
  task automatic strobe(input int kind, input logic [3:0] v);
    @(negedge clk);
    pin_set   = (kind == 0 || kind == 3);
    pin_clr   = (kind == 1 || kind == 3);
    mode_load = (kind == 2);
    mode_val  = v;
    @(posedge clk);
    #1;
    pin_set = 1'b0; pin_clr = 1'b0; mode_load = 1'b0;
  endtask

  // samples now (index start), then one sample after each further edge
  task automatic wave(input string tag, input int per, input int hi, input int start, input int n);
    int bad = 0;
    int first_i = -1;
    int first_a = 0;
    for (int i = 0; i < n; i++) begin
      int e;
      if (i > 0) begin @(posedge clk); #1; end
      e = (((start + i) % per) < hi) ? 1 : 0;
      if (int'(drv_on) != e) begin
        bad++;
        if (first_i < 0) begin first_i = i; first_a = drv_on; end
      end
    end
    check({tag, " waveform mismatches"}, bad, 0);
    if (bad != 0) $display("  first mismatch at sample %0d drv_on=%0d", first_i, first_a);
  endtask

  task automatic hold(input string tag, input int val, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      if (int'(drv_on) != val) bad++;
    end
    check({tag, " static level errors"}, bad, 0);
  endtask

  task automatic t_reset();
    check("R1 out_en after reset", out_en, 0);
    check("R1 drv_on after reset", drv_on, 0);
    strobe(0, 4'd0);
    check("R6 out_en after set", out_en, 1);
    wave("R1 R2 default mode 0", 96, 48, 0, 200);
  endtask

  task automatic t_mode(input string tag, input logic [3:0] v, input int per, input int hi);
    repeat (7) @(posedge clk);
    strobe(2, v);
    wave(tag, per, hi, 0, 2 * per + 5);
  endtask

  task automatic t_static();
    strobe(2, 4'd5);
    hold("R5 mode 5 enabled", 1, 30);
    strobe(1, 4'd0);
    check("R5 out_en after clear", out_en, 0);
    hold("R5 mode 5 cleared", 0, 30);
    strobe(0, 4'd0);
    hold("R5 mode 5 set again", 1, 10);
  endtask

  task automatic t_clear();
    strobe(2, 4'd0);
    repeat (5) @(posedge clk);
    strobe(1, 4'd0);
    check("R6 out_en after clear", out_en, 0);
    hold("R6 carrier off after clear", 0, 120);
    strobe(3, 4'd0);
    check("R6 clear wins over set", out_en, 0);
    hold("R6 still off", 0, 20);
    strobe(0, 4'd0);
    wave("R6 restart after set", 96, 48, 0, 100);
  endtask

  task automatic t_stop();
    strobe(2, 4'd2);
    repeat (10) @(posedge clk);
    @(negedge clk);
    stop = 1'b1;
    #1;
    check("R7 drv_on entering stop", drv_on, 0);
    check("R7 out_en entering stop", out_en, 0);
    @(posedge clk); #1;
    hold("R7 held off in stop", 0, 60);
    @(negedge clk);
    stop = 1'b0;
    #1;
    check("R7 out_en after stop", out_en, 1);
    wave("R7 mode 2 after stop", 64, 32, 0, 140);
    strobe(2, 4'd5);
    @(negedge clk);
    stop = 1'b1;
    #1;
    check("R7 static pin released in stop", drv_on, 0);
    @(negedge clk);
    stop = 1'b0;
    #1;
    check("R7 static pin restored", drv_on, 1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mode("R2 mode 1", 4'd1, 96, 32);
    t_mode("R2 mode 6", 4'd6, 96, 24);
    t_mode("R3 mode 2", 4'd2, 64, 32);
    t_mode("R3 R8 mode 3", 4'd3, 64, 16);
    t_mode("R4 mode 4", 4'd4, 88, 32);
    t_mode("R4 R8 mode 7", 4'd7, 92, 46);
    t_mode("R9 value 8 is mode 0", 4'd8, 96, 48);
    strobe(2, 4'd13);
    hold("R9 value 13 is static mode", 1, 120);
    t_static();
    t_clear();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule